// File: doc/BRIEF.md
# Streaming Five-Point Stencil Window Generator

The block takes one raster-ordered pass over a rectangular grid of 32-bit words, row after row, and turns it into a stream of five-point neighbourhoods. For each grid point it presents the point itself together with the words one row above, one row below, one column to the right and one column to the left. Each input word is read exactly once. The window of recent words lives in a small circular buffer inside the block, so no neighbour is ever fetched again from outside.

A second word travels with every primary word on the same input handshake. It has no neighbourhood. It is delayed inside the block so that it leaves together with the tuple whose centre has the same grid index. Input and output use blocking valid/ready handshakes. Either side may stall the block at any time without data being lost or repeated.

The grid is closed at its sides. A neighbour that would lie outside the grid is replaced by the centre word, and a four-bit flag vector reports which neighbours were replaced. The row length and row count are elaboration parameters. The buffer depths, the fill distance (one row length) and the frame length all follow from them. After the last tuple of a frame, the block pulses a done flag and is ready for the next time step without a reset.

Top module: `stencil_window_gen`

## Requirements
- R1: While rst_ni is low and directly after it, out_valid_o and frame_done_o are 0 and in_ready_o is 1.
- R2: With grid index i = row*ROW_LEN + col, the tuple for index i carries centre = word i, north = word i-ROW_LEN, south = word i+ROW_LEN, east = word i+1 and west = word i-1, for every neighbour inside the grid.
- R3: A neighbour outside the grid is replaced by the centre word. out_edge_o bit 0 (north) is set for row 0, bit 1 (south) for the last row, bit 2 (east) for the last column and bit 3 (west) for column 0.
- R4: out_aux_o carries the in_aux_i word that was accepted together with the tuple's centre word.
- R5: out_valid_o stays 0 until ROW_LEN+1 words of the frame have been accepted. It is 1 in the cycle after the (ROW_LEN+1)-th acceptance.
- R6: While no tuple is taken, the block accepts at most ROW_LEN+1 words more than it has emitted, and in_ready_o is then 0.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, the five tuple words, out_aux_o and out_edge_o stay unchanged into the next cycle.
- R8: Exactly ROW_LEN*ROWS tuples are emitted per frame. frame_done_o is a one-cycle pulse in the cycle after the last tuple transfer, and out_valid_o stays 0 afterwards until new words arrive.
- R9: After frame_done_o the block accepts the next frame with in_ready_o 1 and produces correct tuples again, with no reset in between.
- R10: With in_valid_i and out_ready_i held high, a whole frame completes (frame_done_o seen) within ROW_LEN*ROWS + ROW_LEN + 2 cycles of the first input offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word pair offered |
| in_ready_o | output | 1 | Block can take the input pair |
| in_data_i | input | DW | Primary stream word (raster order) |
| in_aux_i | input | DW | Secondary word, delayed without stencil |
| out_valid_o | output | 1 | Tuple available |
| out_ready_i | input | 1 | Consumer takes the tuple |
| out_c_o | output | DW | Centre word |
| out_n_o | output | DW | North neighbour (previous row) |
| out_s_o | output | DW | South neighbour (next row) |
| out_e_o | output | DW | East neighbour (next column) |
| out_w_o | output | DW | West neighbour (previous column) |
| out_aux_o | output | DW | Secondary word aligned to the centre |
| out_edge_o | output | 4 | Substituted neighbours: bit0 N, bit1 S, bit2 E, bit3 W |
| frame_done_o | output | 1 | One-cycle pulse after the last tuple of a frame |

## Verification
Each word's value encodes its frame number and grid index, so any misplaced tap, wrong substitution or misaligned secondary word shows up as a value mismatch. A continuous stream on both sides checks steady-state throughput, and the fill timing and overwrite safety at the exact point where a write and the north read share a slot. Holding the consumer off at frame start separates a correct fill threshold and window bound from an off-by-one in either. Random gaps on both sides reveal loss, duplication or changes in the held output during stalls. Running frames back to back without reset, with a frame length that is not a multiple of either buffer depth, catches pointers or counters that fail to carry over or re-arm correctly.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int unsigned NTAPS = 5;
  localparam int unsigned TAP_C = 0;
  localparam int unsigned TAP_N = 1;
  localparam int unsigned TAP_S = 2;
  localparam int unsigned TAP_E = 3;
  localparam int unsigned TAP_W = 4;
  localparam int unsigned NEDGE = NTAPS - 1;  // edge bit k-1 belongs to tap k
endpackage

// File: rtl/stencil_seq_ctrl.sv
module stencil_seq_ctrl
  import stencil_pkg::*;
#(
  parameter int unsigned ROW_LEN = 6,
  parameter int unsigned ROWS    = 5,
  parameter int unsigned RW      = $clog2(ROWS),
  parameter int unsigned CLW     = $clog2(ROW_LEN)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic           out_ready_i,
  output logic           in_ready_o,
  output logic           out_valid_o,
  output logic           in_fire_o,
  output logic           out_fire_o,
  output logic [RW-1:0]  row_o,
  output logic [CLW-1:0] col_o,
  output logic           frame_done_o
);
  localparam int unsigned N  = ROW_LEN * ROWS;
  localparam int unsigned D  = ROW_LEN;
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0]  N_C      = CW'(N);
  localparam logic [CW-1:0]  D_C      = CW'(D);
  localparam logic [CW-1:0]  LAST_C   = CW'(N - 1);
  localparam logic [CLW-1:0] COL_LAST = CLW'(ROW_LEN - 1);

  logic [CW-1:0] acc_q, emit_q, lead;
  logic          frame_end, done_q;

  assign lead        = acc_q - emit_q;
  // element i+D buffered, or input exhausted (drain)
  assign out_valid_o = (emit_q != N_C) && ((lead > D_C) || (acc_q == N_C));
  assign out_fire_o  = out_valid_o && out_ready_i;
  // a write at lead D+1 reuses the north slot being read this cycle
  assign in_ready_o  = (acc_q != N_C) && ((lead <= D_C) || out_fire_o);
  assign in_fire_o   = in_valid_i && in_ready_o;
  assign frame_end   = out_fire_o && (emit_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      emit_q <= '0;
      row_o  <= '0;
      col_o  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (frame_end) begin
        acc_q  <= '0;
        emit_q <= '0;
        row_o  <= '0;
        col_o  <= '0;
      end else begin
        if (in_fire_o) acc_q <= acc_q + CW'(1);
        if (out_fire_o) begin
          emit_q <= emit_q + CW'(1);
          if (col_o == COL_LAST) begin
            col_o <= '0;
            row_o <= row_o + RW'(1);
          end else begin
            col_o <= col_o + CLW'(1);
          end
        end
      end
    end
  end

  assign frame_done_o = done_q;

  a_r6_lead_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead <= D_C + CW'(1));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  a_r9_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!out_valid_o && in_ready_o));
  a_r7_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
endmodule

// File: rtl/stencil_window_ram.sv
module stencil_window_ram
  import stencil_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned ROW_LEN = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      adv_i,
  output logic [NTAPS-1:0][DW-1:0]  tap_o
);
  localparam int unsigned DEPTH = 2 * ROW_LEN + 1;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned TAP_OFF [NTAPS] = '{0, DEPTH - ROW_LEN, ROW_LEN, 1, DEPTH - 1};

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, cp_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input int unsigned off);
    int unsigned t;
    t = (32'(p) + off) % DEPTH;
    return AW'(t);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wp_q] <= wr_data_i;
  end

  // pointers keep running across frames; slot = (base + index) mod DEPTH
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      cp_q <= '0;
    end else begin
      if (wr_en_i) wp_q <= step(wp_q, 1);
      if (adv_i)   cp_q <= step(cp_q, 1);
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign tap_o[k] = mem_q[step(cp_q, TAP_OFF[k])];
  end
endmodule

// File: rtl/stencil_aux_delay.sv
module stencil_aux_delay #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_adv_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    int unsigned t;
    t = (32'(p) + 1) % DEPTH;
    return AW'(t);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en_i)  wp_q <= inc(wp_q);
      if (rd_adv_i) rp_q <= inc(rp_q);
    end
  end

  assign rd_data_o = mem_q[rp_q];
endmodule

// File: rtl/stencil_edge_sub.sv
module stencil_edge_sub
  import stencil_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned ROW_LEN = 6,
  parameter int unsigned ROWS    = 5,
  parameter int unsigned RW      = $clog2(ROWS),
  parameter int unsigned CLW     = $clog2(ROW_LEN)
) (
  input  logic [NTAPS-1:0][DW-1:0] tap_i,
  input  logic [RW-1:0]            row_i,
  input  logic [CLW-1:0]           col_i,
  output logic [NTAPS-1:0][DW-1:0] tap_o,
  output logic [NEDGE-1:0]         edge_o
);
  localparam logic [RW-1:0]  ROW_LAST = RW'(ROWS - 1);
  localparam logic [CLW-1:0] COL_LAST = CLW'(ROW_LEN - 1);

  assign edge_o[TAP_N-1] = (row_i == '0);
  assign edge_o[TAP_S-1] = (row_i == ROW_LAST);
  assign edge_o[TAP_E-1] = (col_i == COL_LAST);
  assign edge_o[TAP_W-1] = (col_i == '0);

  assign tap_o[TAP_C] = tap_i[TAP_C];
  for (genvar k = 1; k < NTAPS; k++) begin : g_sub
    assign tap_o[k] = edge_o[k-1] ? tap_i[TAP_C] : tap_i[k];
  end
endmodule

// File: rtl/stencil_window_gen.sv
module stencil_window_gen
  import stencil_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned ROW_LEN = 6,
  parameter int unsigned ROWS    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  input  logic [DW-1:0]    in_aux_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [DW-1:0]    out_c_o,
  output logic [DW-1:0]    out_n_o,
  output logic [DW-1:0]    out_s_o,
  output logic [DW-1:0]    out_e_o,
  output logic [DW-1:0]    out_w_o,
  output logic [DW-1:0]    out_aux_o,
  output logic [NEDGE-1:0] out_edge_o,
  output logic             frame_done_o
);
  localparam int unsigned RW        = $clog2(ROWS);
  localparam int unsigned CLW       = $clog2(ROW_LEN);
  localparam int unsigned AUX_DEPTH = ROW_LEN + 1;

  logic                     in_fire, out_fire;
  logic [RW-1:0]            row;
  logic [CLW-1:0]           col;
  logic [NTAPS-1:0][DW-1:0] raw_tap, sub_tap;

  stencil_seq_ctrl #(.ROW_LEN(ROW_LEN), .ROWS(ROWS), .RW(RW), .CLW(CLW)) ctrl_i (
    .clk_i, .rst_ni, .in_valid_i, .out_ready_i, .in_ready_o, .out_valid_o,
    .in_fire_o(in_fire), .out_fire_o(out_fire), .row_o(row), .col_o(col), .frame_done_o
  );

  stencil_window_ram #(.DW(DW), .ROW_LEN(ROW_LEN)) win_i (
    .clk_i, .rst_ni, .wr_en_i(in_fire), .wr_data_i(in_data_i), .adv_i(out_fire), .tap_o(raw_tap)
  );

  stencil_aux_delay #(.DW(DW), .DEPTH(AUX_DEPTH)) aux_i (
    .clk_i, .rst_ni, .wr_en_i(in_fire), .wr_data_i(in_aux_i), .rd_adv_i(out_fire), .rd_data_o(out_aux_o)
  );

  stencil_edge_sub #(.DW(DW), .ROW_LEN(ROW_LEN), .ROWS(ROWS), .RW(RW), .CLW(CLW)) edge_i (
    .tap_i(raw_tap), .row_i(row), .col_i(col), .tap_o(sub_tap), .edge_o(out_edge_o)
  );

  assign out_c_o = sub_tap[TAP_C];
  assign out_n_o = sub_tap[TAP_N];
  assign out_s_o = sub_tap[TAP_S];
  assign out_e_o = sub_tap[TAP_E];
  assign out_w_o = sub_tap[TAP_W];

  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_c_o) && $stable(out_n_o) && $stable(out_s_o)
      && $stable(out_e_o) && $stable(out_w_o) && $stable(out_aux_o) && $stable(out_edge_o)));
  a_r8_no_valid_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !out_valid_o);
endmodule

// File: tb/stencil_window_gen_tb_top.sv
`timescale 1ns/1ps
module stencil_window_gen_tb_top;
  localparam int DW = 32;
  localparam int RL = 6;
  localparam int RS = 5;
  localparam int N  = RL * RS;
  localparam int D  = RL;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid_i, in_ready_o, out_valid_o, out_ready_i, frame_done_o;
  logic [DW-1:0] in_data_i, in_aux_i;
  logic [DW-1:0] out_c_o, out_n_o, out_s_o, out_e_o, out_w_o, out_aux_o;
  logic [3:0] out_edge_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  stencil_window_gen #(.DW(DW), .ROW_LEN(RL), .ROWS(RS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i, .in_ready_o, .in_data_i, .in_aux_i,
    .out_valid_o, .out_ready_i, .out_c_o, .out_n_o, .out_s_o, .out_e_o, .out_w_o,
    .out_aux_o, .out_edge_o, .frame_done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pv(input int f, input int i);
    return 32'h4000_0000 + 32'(f << 12) + 32'(i);
  endfunction

  function automatic logic [31:0] av(input int f, input int i);
    return 32'hC000_0000 + 32'(f << 16) + 32'(i * 3);
  endfunction

  task automatic check_tuple(input int f, input int i);
    int r, c;
    logic [31:0] ec, en, es, ee, ew;
    logic [3:0] ef;
    r = i / RL;
    c = i % RL;
    ec = pv(f, i);
    ef = {c == 0, c == RL - 1, r == RS - 1, r == 0};
    en = ef[0] ? ec : pv(f, i - RL);
    es = ef[1] ? ec : pv(f, i + RL);
    ee = ef[2] ? ec : pv(f, i + 1);
    ew = ef[3] ? ec : pv(f, i - 1);
    chk(out_c_o == ec, "R2", "centre", out_c_o, ec);
    chk(out_n_o == en, "R2/R3", "north", out_n_o, en);
    chk(out_s_o == es, "R2/R3", "south", out_s_o, es);
    chk(out_e_o == ee, "R2/R3", "east", out_e_o, ee);
    chk(out_w_o == ew, "R2/R3", "west", out_w_o, ew);
    chk(out_edge_o == ef, "R3", "edge flags", 32'(out_edge_o), 32'(ef));
    chk(out_aux_o == av(f, i), "R4", "aux alignment", out_aux_o, av(f, i));
  endtask

  // one frame; in_mode/out_mode 0 = always, 1 = random gaps; hold = cycles with output blocked
  task automatic run_frame(input int f, input int in_mode, input int out_mode,
                           input int hold, output int cycles);
    int sent, rcv, cyc;
    bit done_seen, stall_prev, acc_now;
    logic [31:0] s_c, s_aux;
    logic [3:0] s_edge;
    sent = 0; rcv = 0; cyc = 0;
    done_seen = 0; stall_prev = 0; acc_now = 0;
    s_c = '0; s_aux = '0; s_edge = '0;
    in_valid_i = 1'b0;
    while (cyc < 40 * N) begin
      @(negedge clk);
      if (acc_now) in_valid_i = 1'b0;
      acc_now = 0;
      if (frame_done_o) begin
        done_seen = 1;
        chk(rcv == N, "R8", "tuples before done pulse", 32'(rcv), 32'(N));
      end
      if (stall_prev)
        chk(out_valid_o && out_c_o == s_c && out_aux_o == s_aux && out_edge_o == s_edge,
            "R7", "held output during stall", out_c_o, s_c);
      if (done_seen) break;
      if (!in_valid_i && sent < N && (in_mode == 0 || ($urandom % 3) != 0)) begin
        in_valid_i = 1'b1;
        in_data_i  = pv(f, sent);
        in_aux_i   = av(f, sent);
      end
      out_ready_i = (cyc >= hold) && (out_mode == 0 || ($urandom % 2) == 1);
      #1;
      if (cyc < hold)
        chk(out_valid_o == (sent >= D + 1), "R5", "fill threshold", 32'(out_valid_o), 32'(sent >= D + 1));
      if (hold > 0 && cyc == hold - 1) begin
        chk(sent == D + 1, "R6", "accepted while blocked", 32'(sent), 32'(D + 1));
        chk(!in_ready_o, "R6", "in_ready when window full", 32'(in_ready_o), 32'(0));
      end
      stall_prev = out_valid_o && !out_ready_i;
      s_c = out_c_o; s_aux = out_aux_o; s_edge = out_edge_o;
      if (out_valid_o && out_ready_i) begin
        check_tuple(f, rcv);
        rcv++;
      end
      if (in_valid_i && in_ready_o) begin
        sent++;
        acc_now = 1;
      end
      cyc++;
    end
    in_valid_i = 1'b0;
    chk(done_seen, "R8", "frame done seen", 32'(done_seen), 32'(1));
    cycles = cyc;
    out_ready_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk(!out_valid_o, "R8", "no tuple beyond N", 32'(out_valid_o), 32'(0));
      chk(!frame_done_o, "R8", "done is one cycle", 32'(frame_done_o), 32'(0));
      chk(in_ready_o, "R9", "re-armed for next frame", 32'(in_ready_o), 32'(1));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid_o, "R1", "out_valid in reset", 32'(out_valid_o), 32'(0));
    chk(!frame_done_o, "R1", "frame_done in reset", 32'(frame_done_o), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid_o, "R1", "out_valid after reset", 32'(out_valid_o), 32'(0));
    chk(in_ready_o, "R1", "in_ready after reset", 32'(in_ready_o), 32'(1));
  endtask

  task automatic t_fill_blocked;  // R5, R6
    int cy;
    run_frame(0, 0, 0, 3 * RL, cy);
  endtask

  task automatic t_full_rate;  // R10
    int cy;
    run_frame(1, 0, 0, 0, cy);
    chk(cy <= N + D + 2, "R10", "cycles for full-rate frame", 32'(cy), 32'(N + D + 2));
  endtask

  task automatic t_random_gaps;  // R7, R9
    int cy;
    run_frame(2, 1, 1, 0, cy);
    run_frame(3, 1, 1, 0, cy);
    run_frame(4, 1, 0, 0, cy);
    run_frame(5, 0, 1, 0, cy);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    in_aux_i = '0;
    out_ready_i = 1'b0;
    void'($urandom(7));
    t_reset();
    t_fill_blocked();
    t_full_rate();
    t_random_gaps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule